// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the three timing signals of a serial audio port from one fast source clock. A prescaler first slows the source clock into a root audio clock, which is delivered as a one-cycle enable pulse. The bit clock and the left/right frame clock are then divided from that root clock. Two small select fields choose the ratios, and each field includes ratios that are not powers of two. A one-cycle strobe marks the first bit of every left channel, so that downstream shift logic can align to the frame.

The ratios can also be derived automatically from the sample length. Every combination is checked before the port starts. Combinations that cannot produce an integer bit-clock divide are refused, and so is a 24-bit sample with a 256 or 512 root ratio. All settings are captured while the port is idle and held while it runs. In slave mode the ratio and prescaler settings play no part: the external bit and frame clocks pass straight through to the outputs.

Top module: `aud_clk_gen`

## Requirements
- R1: The root ratio select encodes 0=256, 1=512, 2=384, 3=768 root ticks per frame, so a frame lasts root ratio × prescaler divide source cycles, measured between consecutive `frame_start` pulses.
- R2: The bit ratio select encodes 0=32, 1=48, 2=16, 3=24 bit clocks per frame, and `bclk` shows that many rising edges in each frame.
- R3: The prescaler divide is `psr_div`+1 when `psr_en` is 1 and 1 when `psr_en` is 0, and `root_en` pulses once per divide cycles, which gives root-ratio pulses per frame.
- R4: `lrclk` is low for the first half of each frame (left channel) and high for the second half. `frame_start` is a single-cycle pulse in the first cycle of each frame, including the first frame after start, and `lrclk` is low while it is high.
- R5: With `bit_auto`=1 the bit ratio is twice the sample length, where `len_sel` encodes 0=16, 1=8, 2=24 and 3=16 bits.
- R6: With `root_auto`=1 the root ratio is 256 when the effective bit ratio is 16 or 32, and 384 otherwise.
- R7: A 24-bit sample length with an effective root ratio of 256 or 512 sets `cfg_err`, and the port does not start (`frame_start`, `bclk` and `root_en` stay low).
- R8: If root ratio / (2 × bit ratio) is not an integer, `cfg_err` is set and the port does not start.
- R9: Changes to ratio, length, prescaler or mode inputs while `run` is held are ignored. They take effect at the next start from idle.
- R10: In slave mode `bclk` and `lrclk` follow `ext_bclk` and `ext_lrclk` combinationally, and `root_en` stays low. `frame_start` pulses two cycles after `ext_lrclk` is sampled high and then low.
- R11: While reset is held, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start (1) or stop (0) the port |
| slave_mode | input | 1 | 1: pass the external clocks through |
| root_sel | input | 2 | Root ratio select |
| bit_sel | input | 2 | Bit ratio select |
| root_auto | input | 1 | Derive the root ratio from the bit ratio |
| bit_auto | input | 1 | Derive the bit ratio from the sample length |
| len_sel | input | 2 | Sample length select |
| psr_en | input | 1 | Prescaler enable |
| psr_div | input | 6 | Prescaler divide minus one |
| ext_bclk | input | 1 | External bit clock (slave) |
| ext_lrclk | input | 1 | External frame clock (slave) |
| root_en | output | 1 | Root clock enable pulse |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock, low = left |
| frame_start | output | 1 | First-cycle-of-frame strobe |
| cfg_err | output | 1 | Captured configuration is illegal |

## Verification
The bench builds the block with its default widths: a 6-bit prescaler field, 10-bit root ratios and a 5-bit half-period counter. These widths cover every one of the sixteen ratio pairs and the longest half period of 24 root ticks. Prescaler divides of 1 to 3 keep even the 768-tick frame short enough to measure several frames. This makes the integer and non-integer ratio pairs, both automatic derivations, and the hold-while-running rule all reachable within one short run.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;
  localparam int ROOT_W = 10;
  localparam int BITS_W = 7;
  localparam int HALF_W = 5;
  localparam int PSR_W  = 6;
  localparam int LEN_W  = 5;

  typedef struct packed {
    logic              slave;
    logic [ROOT_W-1:0] root;
    logic [BITS_W-1:0] bits;
    logic [HALF_W-1:0] half;
    logic [PSR_W-1:0]  div_m1;
  } clk_cfg_t;

  function automatic logic [ROOT_W-1:0] root_of(input logic [1:0] sel);
    case (sel)
      2'd1:    return ROOT_W'(512);
      2'd2:    return ROOT_W'(384);
      2'd3:    return ROOT_W'(768);
      default: return ROOT_W'(256);
    endcase
  endfunction

  function automatic logic [BITS_W-1:0] bits_of(input logic [1:0] sel);
    case (sel)
      2'd1:    return BITS_W'(48);
      2'd2:    return BITS_W'(16);
      2'd3:    return BITS_W'(24);
      default: return BITS_W'(32);
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] len_of(input logic [1:0] sel);
    case (sel)
      2'd1:    return LEN_W'(8);
      2'd2:    return LEN_W'(24);
      default: return LEN_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/aud_clk_cfg.sv
module aud_clk_cfg
  import aud_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slave_i,
  input  logic [1:0]       root_sel,
  input  logic [1:0]       bit_sel,
  input  logic             root_auto,
  input  logic             bit_auto,
  input  logic [1:0]       len_sel,
  input  logic             psr_en,
  input  logic [PSR_W-1:0] psr_div,
  output clk_cfg_t         cfg_q,
  output logic             running,
  output logic             start_master,
  output logic             err_q
);
  logic [LEN_W-1:0]  len_live;
  logic [BITS_W-1:0] bits_live;
  logic [ROOT_W-1:0] root_live;
  logic [ROOT_W-1:0] den;
  logic              err_live;
  clk_cfg_t          live;
  clk_cfg_t          eff;
  logic              err_eff;
  logic              go;

  always_comb begin
    len_live  = len_of(len_sel);
    bits_live = bit_auto ? BITS_W'({len_live, 1'b0}) : bits_of(bit_sel);
    if (root_auto)
      root_live = (bits_live == BITS_W'(16) || bits_live == BITS_W'(32)) ?
                  ROOT_W'(256) : ROOT_W'(384);
    else
      root_live = root_of(root_sel);
    den = ROOT_W'({bits_live, 1'b0});
    err_live = ((len_live == LEN_W'(24)) &&
                (root_live == ROOT_W'(256) || root_live == ROOT_W'(512))) ||
               ((root_live % den) != '0);
    live.slave  = slave_i;
    live.root   = root_live;
    live.bits   = bits_live;
    live.half   = HALF_W'(root_live / den);
    live.div_m1 = psr_en ? psr_div : '0;
    eff     = running ? cfg_q : live;
    err_eff = running ? err_q : err_live;
    go      = run && (eff.slave || !err_eff);
    start_master = go && !running && !eff.slave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      err_q   <= 1'b0;
      running <= 1'b0;
    end else begin
      cfg_q   <= eff;
      err_q   <= err_eff;
      running <= go;
    end
  end

  AST_CFG_HELD_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) |-> $stable(cfg_q)); // R9
  AST_ERR_NEVER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !cfg_q.slave |-> !running); // R7
endmodule

// File: rtl/aud_clk_prescale.sv
module aud_clk_prescale
  import aud_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSR_W-1:0] div_m1,
  output logic             tick
);
  logic [PSR_W-1:0] cnt;

  assign tick = en && (cnt == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + PSR_W'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (div_m1 != '0) |=> !tick); // R3
endmodule

// File: rtl/aud_clk_divider.sv
module aud_clk_divider
  import aud_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              tick,
  input  logic [HALF_W-1:0] half,
  input  logic [BITS_W-1:0] bits,
  output logic              bclk,
  output logic              lrclk,
  output logic              frame_start
);
  logic [HALF_W-1:0] half_cnt;
  logic [BITS_W-1:0] bit_cnt;
  logic [BITS_W-1:0] nb;

  always_comb begin
    nb = (bit_cnt == bits - BITS_W'(1)) ? '0 : bit_cnt + BITS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt    <= '0;
      bit_cnt     <= '0;
      bclk        <= 1'b0;
      lrclk       <= 1'b0;
      frame_start <= 1'b0;
    end else if (!en) begin
      half_cnt    <= '0;
      bit_cnt     <= '0;
      bclk        <= 1'b0;
      lrclk       <= 1'b0;
      frame_start <= start;
    end else begin
      frame_start <= 1'b0;
      if (tick) begin
        if (half_cnt == half - HALF_W'(1)) begin
          half_cnt <= '0;
          bclk     <= ~bclk;
          if (bclk) begin
            bit_cnt     <= nb;
            lrclk       <= (nb >= (bits >> 1));
            frame_start <= (nb == '0);
          end
        end else begin
          half_cnt <= half_cnt + HALF_W'(1);
        end
      end
    end
  end

  AST_FRAME_IN_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !lrclk); // R4
  AST_BCLK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && !$past(tick) |-> $stable(bclk)); // R2
endmodule

// File: rtl/aud_clk_gen.sv
module aud_clk_gen
  import aud_clk_pkg::*;
(
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slave_mode,
  input  logic [1:0]       root_sel,
  input  logic [1:0]       bit_sel,
  input  logic             root_auto,
  input  logic             bit_auto,
  input  logic [1:0]       len_sel,
  input  logic             psr_en,
  input  logic [PSR_W-1:0] psr_div,
  input  logic             ext_bclk,
  input  logic             ext_lrclk,
  output logic             root_en,
  output logic             bclk,
  output logic             lrclk,
  output logic             frame_start,
  output logic             cfg_err
);
  clk_cfg_t cfg_q;
  logic     running;
  logic     start_master;
  logic     master_en;
  logic     tick;
  logic     bclk_m, lrclk_m, fs_m;
  logic     lr_q, fs_s;

  aud_clk_cfg u_cfg (
    .clk(clk_src), .rst_n(rst_n), .run(run), .slave_i(slave_mode),
    .root_sel(root_sel), .bit_sel(bit_sel), .root_auto(root_auto),
    .bit_auto(bit_auto), .len_sel(len_sel), .psr_en(psr_en),
    .psr_div(psr_div), .cfg_q(cfg_q), .running(running),
    .start_master(start_master), .err_q(cfg_err)
  );

  assign master_en = running && !cfg_q.slave;

  aud_clk_prescale u_psr (
    .clk(clk_src), .rst_n(rst_n), .en(master_en),
    .div_m1(cfg_q.div_m1), .tick(tick)
  );

  aud_clk_divider u_div (
    .clk(clk_src), .rst_n(rst_n), .en(master_en), .start(start_master),
    .tick(tick), .half(cfg_q.half), .bits(cfg_q.bits),
    .bclk(bclk_m), .lrclk(lrclk_m), .frame_start(fs_m)
  );

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      lr_q <= 1'b0;
      fs_s <= 1'b0;
    end else begin
      lr_q <= ext_lrclk;
      fs_s <= running && cfg_q.slave && lr_q && !ext_lrclk;
    end
  end

  assign root_en     = tick;
  assign bclk        = cfg_q.slave ? ext_bclk  : bclk_m;
  assign lrclk       = cfg_q.slave ? ext_lrclk : lrclk_m;
  assign frame_start = cfg_q.slave ? fs_s      : fs_m;

  AST_SLAVE_NO_ROOT: assert property (@(posedge clk_src) disable iff (!rst_n)
    cfg_q.slave |-> !root_en); // R10
  AST_NO_TICK_IDLE: assert property (@(posedge clk_src) disable iff (!rst_n)
    !running |-> !root_en); // R3
endmodule

// File: tb/aud_clk_gen_tb_top.sv
module aud_clk_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, slave_mode = 0, root_auto = 0, bit_auto = 0, psr_en = 0;
  logic [1:0] root_sel = 0, bit_sel = 0, len_sel = 0;
  logic [5:0] psr_div = 0;
  logic ext_bclk = 0, ext_lrclk = 0;
  logic root_en, bclk, lrclk, frame_start, cfg_err;
  int checks = 0, errors = 0, cyc_total = 0;

  always #5 clk = ~clk;

  aud_clk_gen dut_i (
    .clk_src(clk), .rst_n(rst_n), .run(run), .slave_mode(slave_mode),
    .root_sel(root_sel), .bit_sel(bit_sel), .root_auto(root_auto),
    .bit_auto(bit_auto), .len_sel(len_sel), .psr_en(psr_en),
    .psr_div(psr_div), .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk),
    .root_en(root_en), .bclk(bclk), .lrclk(lrclk),
    .frame_start(frame_start), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [1:0] rs, bs;
    logic       ra, ba;
    logic [1:0] ln;
    logic       pe;
    logic [5:0] pf;
    logic       err;
    int         root, bits, div;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 6'd0, 1'b0, 256, 32, 1},
    '{2'd1, 2'd2, 1'b0, 1'b0, 2'd0, 1'b1, 6'd1, 1'b0, 512, 16, 2},
    '{2'd2, 2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 6'd0, 1'b0, 384, 48, 1},
    '{2'd3, 2'd3, 1'b0, 1'b0, 2'd0, 1'b1, 6'd0, 1'b0, 768, 24, 1},
    '{2'd2, 2'd3, 1'b0, 1'b0, 2'd0, 1'b1, 6'd2, 1'b0, 384, 24, 3},
    '{2'd0, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 6'd5, 1'b0, 256, 16, 1},
    '{2'd0, 2'd0, 1'b1, 1'b1, 2'd1, 1'b1, 6'd0, 1'b0, 256, 16, 1},
    '{2'd0, 2'd0, 1'b1, 1'b1, 2'd2, 1'b1, 6'd0, 1'b0, 384, 48, 1},
    '{2'd0, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 6'd0, 1'b0, 256, 32, 1},
    '{2'd3, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1, 6'd0, 1'b0, 768, 48, 1},
    '{2'd0, 2'd1, 1'b1, 1'b0, 2'd0, 1'b1, 6'd0, 1'b0, 384, 48, 1},
    '{2'd0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b1, 6'd0, 1'b1, 0, 0, 1},
    '{2'd1, 2'd1, 1'b0, 1'b0, 2'd0, 1'b1, 6'd0, 1'b1, 0, 0, 1},
    '{2'd0, 2'd3, 1'b0, 1'b0, 2'd0, 1'b1, 6'd0, 1'b1, 0, 0, 1},
    '{2'd0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 6'd0, 1'b1, 0, 0, 1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(negedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
      summary();
      $finish;
    end
  end

  task automatic apply(input vec_t v);
    root_sel = v.rs; bit_sel = v.bs; root_auto = v.ra; bit_auto = v.ba;
    len_sel = v.ln; psr_en = v.pe; psr_div = v.pf;
  endtask

  // Waits for frame_start, then measures one frame
  task automatic measure(output int cyc, output int rises, output int lrh,
                         output int roots, output int lr_at_fs);
    bit pb;
    cyc = 0; rises = 0; lrh = 0; roots = 0; lr_at_fs = -1;
    for (int w = 0; w < 5000 && !frame_start; w++) @(negedge clk);
    if (!frame_start) return;
    lr_at_fs = int'(lrclk);
    pb = bclk;
    for (int k = 0; k < 5000; k++) begin
      cyc++;
      if (lrclk) lrh++;
      if (root_en) roots++;
      if (bclk && !pb) rises++;
      pb = bclk;
      @(negedge clk);
      if (frame_start) break;
    end
  endtask

  initial begin
    int cyc, rises, lrh, roots, lr0;
    string tag;
    // R11: reset state
    repeat (3) @(negedge clk);
    check(!root_en && !bclk && !lrclk && !frame_start && !cfg_err, "R11 reset outputs",
          int'({root_en, bclk, lrclk, frame_start, cfg_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      run = 1'b0;
      repeat (4) @(negedge clk);
      run = 1'b1;
      tag = (VEC[i].ra || VEC[i].ba) ? "R5/R6 " : "";
      if (VEC[i].err) begin
        // R7 / R8: refused configuration
        bit seen = 0;
        for (int k = 0; k < 60; k++) begin
          @(negedge clk);
          if (frame_start || bclk || root_en) seen = 1;
        end
        check(cfg_err, "R7/R8 cfg_err set", int'(cfg_err), 1);
        check(!seen, "R7/R8 port did not start", int'(seen), 0);
      end else begin
        @(negedge clk);
        check(!cfg_err, {tag, "R1 cfg_err clear"}, int'(cfg_err), 0);
        measure(cyc, rises, lrh, roots, lr0);
        check(lr0 == 0, {tag, "R4 lrclk low at frame_start"}, lr0, 0);
        check(cyc == VEC[i].root * VEC[i].div, {tag, "R1 frame period"},
              cyc, VEC[i].root * VEC[i].div);
        check(rises == VEC[i].bits, {tag, "R2 bclk edges per frame"}, rises, VEC[i].bits);
        check(lrh == cyc / 2, {tag, "R4 lrclk high half"}, lrh, VEC[i].root * VEC[i].div / 2);
        check(roots == VEC[i].root, {tag, "R3 root_en pulses per frame"}, roots, VEC[i].root);
      end
      run = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R9: changes while running are ignored, accepted after idle
    apply(VEC[0]);
    repeat (3) @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    measure(cyc, rises, lrh, roots, lr0);
    root_sel = 2'd3;
    bit_sel = 2'd3;
    measure(cyc, rises, lrh, roots, lr0);
    check(cyc == 256, "R9 period unchanged while running", cyc, 256);
    check(rises == 32, "R9 bit ratio unchanged while running", rises, 32);
    run = 1'b0;
    repeat (4) @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    measure(cyc, rises, lrh, roots, lr0);
    check(cyc == 768, "R9 new ratio taken after idle", cyc, 768);
    run = 1'b0;
    repeat (3) @(negedge clk);

    // R10: slave passthrough
    begin
      logic l0, l1;
      int bad_pass, bad_fs, bad_root, fs_cnt;
      slave_mode = 1'b1;
      repeat (3) @(negedge clk);
      run = 1'b1;
      bad_pass = 0; bad_fs = 0; bad_root = 0; fs_cnt = 0;
      l0 = 0; l1 = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (k > 2) begin
          if (frame_start != (l0 && !l1)) bad_fs++;
          if (frame_start) fs_cnt++;
        end
        if (root_en) bad_root++;
        l0 = l1;
        ext_bclk = ~ext_bclk;
        ext_lrclk = ((k / 8) % 2) == 1;
        l1 = ext_lrclk;
        #1;
        if (bclk != ext_bclk || lrclk != ext_lrclk) bad_pass++;
      end
      check(bad_pass == 0, "R10 clocks passed through", bad_pass, 0);
      check(bad_fs == 0, "R10 frame_start after external fall", bad_fs, 0);
      check(fs_cnt > 0, "R10 frame_start seen in slave", fs_cnt, 4);
      check(bad_root == 0, "R10 root_en low in slave", bad_root, 0);
      run = 1'b0;
    end

    summary();
    $finish;
  end
endmodule